// File: doc/BRIEF.md
# Internal data memory access decoder

This block holds the 1024 bytes of on-chip data storage of an 8051-style core and steers every access to one destination. Storage is split into 256 bytes of scratch RAM and 768 bytes of expanded RAM. The destination depends on three things: the access kind (direct, indirect or external move), the address, and a single extended-RAM disable bit.

Direct accesses to the upper half of the 8-bit space go to the special-function-register bus. MOVX accesses that the block does not serve itself go to an external memory request port.

Requests are synchronous: one request per clock, with a write enable. Writes take effect on the clock edge that accepts them. Read data is presented one clock after the request. SFR and external reads use the same one-cycle return: the responder drives its read data in the cycle after it is selected, and the block passes that data through.

Top module: `dmem_router`

## Requirements
- R1: After reset the extended-RAM disable bit reads 0, so the expanded RAM is enabled. `rd_valid` is 0 after reset.
- R2: A direct access (`req_kind`=00) to addresses 00h–7Fh reaches scratch RAM. It reaches the same bytes that an indirect access to the same address reaches. Address bits 15:8 are ignored for direct and indirect kinds.
- R3: A direct access to addresses 80h–FFh selects only the SFR bus, with `sfr_addr` equal to the low address byte and `sfr_we`/`sfr_wdata` following the request. It never touches the upper scratch RAM.
- R4: An indirect access (`req_kind`=01, and also the unused code 11) to addresses 80h–FFh reaches the upper 128 bytes of scratch RAM.
- R5: A MOVX access (`req_kind`=10) with the disable bit clear and address 0000h–02FFh reaches the expanded RAM. The expanded RAM is separate storage from scratch RAM.
- R6: A MOVX access with address 0300h or above, or any MOVX access while the disable bit is set, selects only the external port. `ext_addr` carries the full 16-bit address, and `ext_we`/`ext_wdata` follow the request.
- R7: A read request gives `rd_valid`=1 and valid `rd_data` exactly one clock later. A write request, or no request, gives `rd_valid`=0 in the next clock.
- R8: Every valid request raises exactly one of `scr_hit`, `xram_hit`, `sfr_sel`, `ext_sel`. With no request, none of them is raised.
- R9: Writing the disable bit through `cfg_we`/`cfg_d` changes only the routing. Contents held in the expanded RAM survive setting the bit and clearing it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_kind | input | 2 | 00 direct, 01 indirect, 10 MOVX, 11 treated as indirect |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| cfg_we | input | 1 | Load the extended-RAM disable bit |
| cfg_d | input | 1 | New value of the disable bit |
| xram_off | output | 1 | Current extended-RAM disable bit |
| rd_valid | output | 1 | Read data valid (one cycle after a read) |
| rd_data | output | 8 | Read data |
| scr_hit | output | 1 | Access served by scratch RAM |
| xram_hit | output | 1 | Access served by expanded RAM |
| sfr_sel | output | 1 | SFR bus select |
| sfr_we | output | 1 | SFR write enable |
| sfr_addr | output | 8 | SFR address |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data, due one cycle after select |
| ext_sel | output | 1 | External memory select |
| ext_we | output | 1 | External write enable |
| ext_addr | output | 16 | External address |
| ext_wdata | output | 8 | External write data |
| ext_rdata | input | 8 | External read data, due one cycle after select |

## Verification
The destination strobes and the SFR/external address and write fields are combinational. The bench therefore samples them 1 ns after it drives a request, in the same cycle. Read data and `rd_valid` belong to the following cycle, so the bench samples them at the next falling edge, after exactly one rising edge.

Writes are checked by reading the location back in a later request. The bench models the SFR and external responders as registers loaded on the select edge, which gives their data the same one-cycle offset.

// File: rtl/dmem_router.sv
module dmem_router #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int SCR_BYTES  = 256,
  parameter int XRAM_BYTES = 768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              cfg_we,
  input  logic              cfg_d,
  output logic              xram_off,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              scr_hit,
  output logic              xram_hit,
  output logic              sfr_sel,
  output logic              sfr_we,
  output logic [7:0]        sfr_addr,
  output logic [DATA_W-1:0] sfr_wdata,
  input  logic [DATA_W-1:0] sfr_rdata,
  output logic              ext_sel,
  output logic              ext_we,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  input  logic [DATA_W-1:0] ext_rdata
);
  localparam int SCR_AW  = $clog2(SCR_BYTES);
  localparam int XRAM_AW = $clog2(XRAM_BYTES);
  localparam logic [ADDR_W-1:0] XRAM_END = ADDR_W'(XRAM_BYTES);

  typedef enum logic [1:0] {SRC_SCR, SRC_XRAM, SRC_SFR, SRC_EXT} src_e;

  logic [DATA_W-1:0] scr_mem  [SCR_BYTES];
  logic [DATA_W-1:0] xram_mem [XRAM_BYTES];
  logic [DATA_W-1:0] scr_q, xram_q;
  logic [SCR_AW-1:0]  scr_idx;
  logic [XRAM_AW-1:0] xram_idx;
  logic is_direct, is_movx, upper_half, xram_in_range;
  src_e src_q;

  assign is_direct     = req_kind == 2'b00;
  assign is_movx       = req_kind == 2'b10;
  assign upper_half    = req_addr[SCR_AW-1];
  assign xram_in_range = req_addr < XRAM_END;
  assign scr_idx       = req_addr[SCR_AW-1:0];
  assign xram_idx      = req_addr[XRAM_AW-1:0];

  assign sfr_sel  = req_valid && is_direct && upper_half;
  assign scr_hit  = req_valid && !is_movx && !(is_direct && upper_half);
  assign xram_hit = req_valid && is_movx && !xram_off && xram_in_range;
  assign ext_sel  = req_valid && is_movx && (xram_off || !xram_in_range);

  assign sfr_we    = sfr_sel && req_we;
  assign sfr_addr  = req_addr[7:0];
  assign sfr_wdata = req_wdata;
  assign ext_we    = ext_sel && req_we;
  assign ext_addr  = req_addr;
  assign ext_wdata = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) xram_off <= 1'b0;
    else if (cfg_we) xram_off <= cfg_d;
  end

  always_ff @(posedge clk) begin
    if (scr_hit) begin
      if (req_we) scr_mem[scr_idx] <= req_wdata;
      else        scr_q <= scr_mem[scr_idx];
    end
    if (xram_hit) begin
      if (req_we) xram_mem[xram_idx] <= req_wdata;
      else        xram_q <= xram_mem[xram_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      src_q    <= SRC_SCR;
    end else begin
      rd_valid <= req_valid && !req_we;
      if (req_valid && !req_we)
        src_q <= sfr_sel ? SRC_SFR : xram_hit ? SRC_XRAM : ext_sel ? SRC_EXT : SRC_SCR;
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_XRAM: rd_data = xram_q;
      SRC_SFR:  rd_data = sfr_rdata;
      SRC_EXT:  rd_data = ext_rdata;
      default:  rd_data = scr_q;
    endcase
  end
endmodule

module dmem_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_we,
  input logic [1:0]  req_kind,
  input logic [15:0] req_addr,
  input logic        scr_hit,
  input logic        xram_hit,
  input logic        sfr_sel,
  input logic        ext_sel,
  input logic        rd_valid,
  input logic        xram_off
);
  AST_ONE_DEST:   assert property (@(posedge clk) disable iff (!rst_n) req_valid |-> $countones({scr_hit, xram_hit, sfr_sel, ext_sel}) == 1); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |-> !(scr_hit || xram_hit || sfr_sel || ext_sel)); // R8
  AST_SFR_DIRECT: assert property (@(posedge clk) disable iff (!rst_n) sfr_sel |-> (req_kind == 2'b00 && req_addr[7])); // R3
  AST_XRAM_WIN:   assert property (@(posedge clk) disable iff (!rst_n) xram_hit |-> (req_kind == 2'b10 && !xram_off && req_addr < 16'h0300)); // R5
  AST_EXT_MOVX:   assert property (@(posedge clk) disable iff (!rst_n) ext_sel |-> (req_kind == 2'b10 && (xram_off || req_addr >= 16'h0300))); // R6
  AST_RD_LAT:     assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !req_we) |=> rd_valid); // R7
  AST_WR_NODATA:  assert property (@(posedge clk) disable iff (!rst_n) (!req_valid || req_we) |=> !rd_valid); // R7
endmodule

bind dmem_router dmem_router_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
  .req_kind(req_kind), .req_addr(req_addr), .scr_hit(scr_hit),
  .xram_hit(xram_hit), .sfr_sel(sfr_sel), .ext_sel(ext_sel),
  .rd_valid(rd_valid), .xram_off(xram_off)
);

// File: tb/tb_dmem_router.sv
module tb_dmem_router;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0, cfg_we = 0, cfg_d = 0;
  logic [1:0] req_kind = 0;
  logic [15:0] req_addr = 0;
  logic [7:0] req_wdata = 0;
  logic xram_off, rd_valid, scr_hit, xram_hit, sfr_sel, sfr_we, ext_sel, ext_we;
  logic [7:0] rd_data, sfr_addr, sfr_wdata, ext_wdata;
  logic [7:0] sfr_rdata = 0, ext_rdata = 0;
  logic [15:0] ext_addr;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  dmem_router dut (.*);

  always @(posedge clk) begin
    if (sfr_sel && !sfr_we) sfr_rdata <= sfr_addr ^ 8'h5A;
    if (ext_sel && !ext_we) ext_rdata <= ext_addr[7:0] ^ ext_addr[15:8] ^ 8'hC3;
  end

  // {kind, addr, strobes {scr,xram,sfr,ext}}
  localparam logic [21:0] VEC [12] = '{
    {2'b00, 16'h007F, 4'b1000}, {2'b00, 16'h0080, 4'b0010},
    {2'b01, 16'h007F, 4'b1000}, {2'b01, 16'h0080, 4'b1000},
    {2'b01, 16'h00FF, 4'b1000}, {2'b10, 16'h02FF, 4'b0100},
    {2'b10, 16'h0300, 4'b0001}, {2'b10, 16'hFFFF, 4'b0001},
    {2'b10, 16'h0000, 4'b0100}, {2'b00, 16'h00FF, 4'b0010},
    {2'b11, 16'h0080, 4'b1000}, {2'b00, 16'h1234, 4'b1000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [1:0] k, input logic [15:0] a, input logic we,
                     input logic [7:0] wd, output logic [3:0] strb,
                     output logic [7:0] rd, output logic rv);
    @(negedge clk);
    req_valid = 1; req_kind = k; req_addr = a; req_we = we; req_wdata = wd;
    #1 strb = {scr_hit, xram_hit, sfr_sel, ext_sel};
    @(negedge clk);
    rd = rd_data; rv = rd_valid;
    req_valid = 0; req_we = 0;
  endtask

  task automatic set_off(input logic v);
    @(negedge clk); cfg_we = 1; cfg_d = v;
    @(negedge clk); cfg_we = 0;
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [3:0] s; logic [7:0] d; logic v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 xram_off", xram_off, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R8 idle strobes", {scr_hit, xram_hit, sfr_sel, ext_sel}, 0);

    for (int i = 0; i < 12; i++) begin
      logic [1:0] k; logic [15:0] a; logic [7:0] e;
      k = VEC[i][21:20]; a = VEC[i][19:4];
      acc(k, a, 0, 0, s, d, v);
      chk("R8 strobes", s, VEC[i][3:0]);
      chk("R7 rd_valid after read", v, 1);
      if (VEC[i][1]) chk("R3 sfr read data", d, a[7:0] ^ 8'h5A);
      if (VEC[i][0]) begin
        e = a[7:0] ^ a[15:8] ^ 8'hC3;
        chk("R6 ext read data", d, e);
      end
    end

    acc(2'b00, 16'h0020, 1, 8'h11, s, d, v);
    chk("R7 no rd_valid on write", v, 0);
    acc(2'b01, 16'h0020, 0, 0, s, d, v);
    chk("R2 direct/indirect share", d, 8'h11);
    acc(2'b00, 16'hAB21, 1, 8'h22, s, d, v);
    acc(2'b01, 16'h0021, 0, 0, s, d, v);
    chk("R2 upper address ignored", d, 8'h22);

    acc(2'b01, 16'h0090, 1, 8'h77, s, d, v);
    @(negedge clk);
    req_valid = 1; req_kind = 2'b00; req_addr = 16'h0090; req_we = 1; req_wdata = 8'hEE;
    #1;
    chk("R3 sfr_we", sfr_we, 1);
    chk("R3 sfr_addr", sfr_addr, 8'h90);
    chk("R3 sfr_wdata", sfr_wdata, 8'hEE);
    @(negedge clk); req_valid = 0; req_we = 0;
    acc(2'b01, 16'h0090, 0, 0, s, d, v);
    chk("R4 upper scratch untouched by direct", d, 8'h77);
    acc(2'b11, 16'h0090, 0, 0, s, d, v);
    chk("R4 kind 11 as indirect", d, 8'h77);

    acc(2'b01, 16'h0010, 1, 8'h99, s, d, v);
    acc(2'b10, 16'h0010, 1, 8'h3C, s, d, v);
    acc(2'b01, 16'h0010, 0, 0, s, d, v);
    chk("R5 scratch separate from xram", d, 8'h99);
    acc(2'b10, 16'h0010, 0, 0, s, d, v);
    chk("R5 xram readback", d, 8'h3C);
    acc(2'b10, 16'h02FF, 1, 8'hE1, s, d, v);
    acc(2'b10, 16'h02FF, 0, 0, s, d, v);
    chk("R5 xram top byte", d, 8'hE1);

    @(negedge clk);
    req_valid = 1; req_kind = 2'b10; req_addr = 16'h0300; req_we = 1; req_wdata = 8'h4D;
    #1;
    chk("R6 ext_we", ext_we, 1);
    chk("R6 ext_addr", ext_addr, 16'h0300);
    chk("R6 ext_wdata", ext_wdata, 8'h4D);
    @(negedge clk); req_valid = 0; req_we = 0;

    set_off(1);
    chk("R9 bit set", xram_off, 1);
    acc(2'b10, 16'h0010, 0, 0, s, d, v);
    chk("R6 disabled xram goes external", s, 4'b0001);
    chk("R6 disabled read data", d, 8'h10 ^ 8'h00 ^ 8'hC3);
    set_off(0);
    acc(2'b10, 16'h0010, 0, 0, s, d, v);
    chk("R9 xram kept across toggle", d, 8'h3C);
    chk("R9 xram routed again", s, 4'b0100);

    @(negedge clk);
    chk("R7 idle rd_valid", rd_valid, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule